// File: doc/BRIEF.md
# Flash cache control and flush register block

This block is the software-visible control point of a flash execute-in-place cache. It holds three control bits: cache enable, power-down and an error-on-bad-write bit. It runs a tag-memory clear walk, and it keeps two saturating performance counters. The cache datapath reads the control bits from dedicated outputs. It pulses a strobe for every access and another for every access served from cached data, and the block counts both.

A clear walk visits each tag index once, one index per clock, from 0 up to the last entry. It asserts a clear strobe with each index. The data array is never touched. A walk starts on its own when reset is released, and it also starts when software writes a 1 to the flush register. Software can wait for the end of a walk in either of two ways:
- poll the status register, or
- read the flush register, which holds the bus until the walk has finished.

The register bus is word-addressed with a single-cycle request. A read returns data in the same cycle unless `ready_o` is held low. An access to an unused word raises `err_o`.

Top module: `xcache_ctrl_regs`

## Requirements
- R1: After reset the control word (address 0) reads 0x3: enable at bit 0 is 1, bad-write-error at bit 1 is 1, power-down at bit 3 is 0. Bit 2 and bits 31:4 always read 0.
- R2: A control write sets power-down from wdata bit 3 and bad-write-error from wdata bit 1. It sets enable to wdata bit 0 AND NOT wdata bit 3. `cache_en_o` and `power_down_o` are never 1 together.
- R3: A write to the flush word (address 1) with wdata bit 0 = 1 starts a walk. From the cycle after that write edge, `tag_clr_o` is 1 and `tag_idx_o` steps 0, 1, …, 2^IDX_W−1, one index per cycle. `tag_clr_o` is 0 afterwards. A flush write with bit 0 = 0 starts nothing.
- R4: A walk starting at index 0 begins automatically when reset is released.
- R5: Status word (address 2) bit 0 reads 0 while a walk runs and 1 otherwise. Its other bits read 0.
- R6: A read of the flush word keeps `ready_o` low while a walk runs. Once the walk is over, the read completes with data 0.
- R7: A flush request during a running walk restarts it from index 0. The restarted walk still covers every index.
- R8: The hit counter (address 3) and the access counter (address 4) are CTR_W bits wide (32 by default). Each stops at all-ones instead of wrapping.
- R9: Any write to a counter word clears it to 0, whatever the data. If a clear and an increment strobe occur in the same cycle, the clear wins.
- R10: The hit counter increments once per cycle in which `hit_stb_i` is 1. The access counter increments once per cycle in which `acc_stb_i` is 1.
- R11: A request to an address above 4 drives `err_o` high in that cycle and changes no register. Requests to addresses 0 to 4 never raise `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when ready_o is high |
| ready_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Access to an unused address |
| cache_en_o | output | 1 | Cache enable |
| bad_wr_err_o | output | 1 | Fault writes to non-allocating aliases |
| power_down_o | output | 1 | Cache memories powered down |
| hit_stb_i | input | 1 | One access served from the cache |
| acc_stb_i | input | 1 | One cache access of any kind |
| tag_clr_o | output | 1 | Clear the tag entry at tag_idx_o |
| tag_idx_o | output | IDX_W | Tag index being cleared |

## Verification
The following outputs are combinational from the request and settle in the cycle of the request:
- read data,
- `err_o`,
- `ready_o`.

A write, or a strobe to a counter, becomes visible on a read from the cycle after the clock edge that accepts it. Walk index k appears on `tag_idx_o` k cycles after the edge that accepts the flush write. The bench changes inputs on the falling edge and samples outputs 1 ns after a rising edge. For each rising edge it counts forward to the cycle a result is due and compares there. Counter expectations come from a saturating model that advances with each strobe the bench drives.

// File: rtl/xcache_ctrl_pkg.sv
package xcache_ctrl_pkg;
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_FLUSH = 1;
  localparam int unsigned REG_STAT  = 2;
  localparam int unsigned REG_HIT   = 3;
  localparam int unsigned REG_ACC   = 4;
  localparam int unsigned NUM_CTR   = 2;
  localparam int unsigned CTR_HIT   = 0;
  localparam int unsigned CTR_ACC   = 1;

  typedef struct packed {
    logic pwr_dn;
    logic rsvd;
    logic bad_wr;
    logic en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{pwr_dn: 1'b0, rsvd: 1'b0, bad_wr: 1'b1, en: 1'b1};
endpackage

// File: rtl/xcache_flush_seq.sv
module xcache_flush_seq #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  // reset leaves the walk armed at index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/xcache_perf_ctr.sv
module xcache_perf_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/xcache_ctrl_regs.sv
module xcache_ctrl_regs
  import xcache_ctrl_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CTR_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic              cache_en_o,
  output logic              bad_wr_err_o,
  output logic              power_down_o,
  input  logic              hit_stb_i,
  input  logic              acc_stb_i,
  output logic              tag_clr_o,
  output logic [IDX_W-1:0]  tag_idx_o
);
  localparam int unsigned NUM_REG = REG_ACC + 1;

  logic [NUM_REG-1:0] sel;
  logic               flush_busy;
  logic               flush_req;
  ctrl_t              ctrl_q;
  logic [NUM_CTR-1:0] ctr_clr;
  logic [NUM_CTR-1:0] ctr_inc;
  logic [CTR_W-1:0]   ctr_val [NUM_CTR];
  logic [CTR_W-1:0]   hit_cnt;
  logic               hit_clr;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_dec
    assign sel[g] = req_i && (addr_i == ADDR_W'(g));
  end

  assign err_o     = req_i && (sel == '0);
  assign ready_o   = !(sel[REG_FLUSH] && !we_i && flush_busy);
  assign flush_req = sel[REG_FLUSH] && we_i && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (sel[REG_CTRL] && we_i) begin
      ctrl_q.pwr_dn <= wdata_i[3];
      ctrl_q.rsvd   <= 1'b0;
      ctrl_q.bad_wr <= wdata_i[1];
      ctrl_q.en     <= wdata_i[0] && !wdata_i[3]; // power-down overrides enable
    end
  end

  assign cache_en_o   = ctrl_q.en;
  assign bad_wr_err_o = ctrl_q.bad_wr;
  assign power_down_o = ctrl_q.pwr_dn;

  xcache_flush_seq #(.IDX_W(IDX_W)) u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(flush_req),
    .busy_o (flush_busy),
    .idx_o  (tag_idx_o)
  );

  assign tag_clr_o = flush_busy;

  assign ctr_inc[CTR_HIT] = hit_stb_i;
  assign ctr_inc[CTR_ACC] = acc_stb_i;
  assign ctr_clr[CTR_HIT] = sel[REG_HIT] && we_i;
  assign ctr_clr[CTR_ACC] = sel[REG_ACC] && we_i;

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    xcache_perf_ctr #(.W(CTR_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (ctr_clr[c]),
      .inc_i (ctr_inc[c]),
      .cnt_o (ctr_val[c])
    );
  end

  assign hit_cnt = ctr_val[CTR_HIT];
  assign hit_clr = ctr_clr[CTR_HIT];

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel[REG_CTRL]: rdata_o = {28'd0, ctrl_q.pwr_dn, 1'b0, ctrl_q.bad_wr, ctrl_q.en};
      sel[REG_STAT]: rdata_o = {31'd0, !flush_busy};
      sel[REG_HIT]:  rdata_o = 32'(ctr_val[CTR_HIT]);
      sel[REG_ACC]:  rdata_o = 32'(ctr_val[CTR_ACC]);
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/xcache_ctrl_chk.sv
module xcache_ctrl_chk #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CTR_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_o,
  input logic              cache_en_o,
  input logic              power_down_o,
  input logic              tag_clr_o,
  input logic [IDX_W-1:0]  tag_idx_o,
  input logic              flush_req,
  input logic [CTR_W-1:0]  hit_cnt,
  input logic              hit_clr
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;
  localparam logic [CTR_W-1:0] SAT      = '1;

  p_en_pd_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cache_en_o && power_down_o));

  p_walk_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_clr_o && !flush_req && tag_idx_o != LAST_IDX)
    |=> (tag_clr_o && tag_idx_o == $past(tag_idx_o) + 1'b1));

  p_walk_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_clr_o && !flush_req && tag_idx_o == LAST_IDX) |=> !tag_clr_o);

  p_flush_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(1) && tag_clr_o) |-> !ready_o);

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req |=> (tag_clr_o && tag_idx_o == '0));

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt == SAT && !hit_clr) |=> hit_cnt == SAT);

  p_clr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_clr |=> hit_cnt == '0);
endmodule

bind xcache_ctrl_regs xcache_ctrl_chk #(.IDX_W(IDX_W), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .ready_o     (ready_o),
  .cache_en_o  (cache_en_o),
  .power_down_o(power_down_o),
  .tag_clr_o   (tag_clr_o),
  .tag_idx_o   (tag_idx_o),
  .flush_req   (flush_req),
  .hit_cnt     (hit_cnt),
  .hit_clr     (hit_clr)
);

// File: tb/test_xcache_ctrl_regs.sv
module test_xcache_ctrl_regs;
  localparam int IDX_W = 4;
  localparam int CTR_W = 6;
  localparam int DEPTH = 1 << IDX_W;
  localparam int CMAX  = (1 << CTR_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, hit_stb = 1'b0, acc_stb = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic ready_o, err_o, cache_en_o, bad_wr_err_o, power_down_o, tag_clr_o;
  logic [IDX_W-1:0] tag_idx_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  xcache_ctrl_regs #(.IDX_W(IDX_W), .CTR_W(CTR_W), .ADDR_W(3)) i_xcache_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_o), .ready_o(ready_o), .err_o(err_o), .cache_en_o(cache_en_o),
    .bad_wr_err_o(bad_wr_err_o), .power_down_o(power_down_o), .hit_stb_i(hit_stb),
    .acc_stb_i(acc_stb), .tag_clr_o(tag_clr_o), .tag_idx_o(tag_idx_o));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic int sat(input int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; req = 0; we = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output int waits, output logic e);
    @(negedge clk); req = 1; we = 0; addr = a; waits = 0;
    #1;
    while (!ready_o) begin @(negedge clk); #1; waits++; end
    d = rdata_o; e = err_o;
    @(posedge clk); #1; req = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    int w; logic e;
    bus_read(a, d, w, e);
  endtask

  // sample walk starting 1 ns after the accepting edge
  task automatic check_walk(input string r);
    for (int i = 0; i < DEPTH; i++) begin
      chk({r, " clr"}, 32'(tag_clr_o), 32'd1);
      chk({r, " idx"}, 32'(tag_idx_o), 32'(i));
      @(posedge clk); #1;
    end
    chk({r, " end"}, 32'(tag_clr_o), 32'd0);
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_up();
  end

  initial begin
    logic [31:0] d, ctrl_before;
    int w, hc, ac;
    logic e;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R4 clr after reset", 32'(tag_clr_o), 32'd1);
    chk("R4 idx after reset", 32'(tag_idx_o), 32'd0);
    rd(3'd2, d); chk("R5 status busy", d, 32'd0);
    rd(3'd0, d); chk("R1 ctrl reset", d, 32'h3);
    chk("R1 en pin", 32'(cache_en_o), 32'd1);
    chk("R1 bw pin", 32'(bad_wr_err_o), 32'd1);
    bus_read(3'd1, d, w, e);
    chk("R6 stalled", 32'(w > 0), 32'd1);
    chk("R6 flush read data", d, 32'd0);
    chk("R6 walk done", 32'(tag_clr_o), 32'd0);
    rd(3'd2, d); chk("R5 status idle", d, 32'd1);
    bus_read(3'd1, d, w, e);
    chk("R6 no stall idle", 32'(w), 32'd0);

    // control writes
    bus_write(3'd0, 32'h9); rd(3'd0, d); chk("R2 pd forces en off", d, 32'h8);
    chk("R2 en pin", 32'(cache_en_o), 32'd0);
    chk("R2 pd pin", 32'(power_down_o), 32'd1);
    bus_write(3'd0, 32'hF); rd(3'd0, d); chk("R1 rsvd bit2", d, 32'hA);
    bus_write(3'd0, 32'h1); rd(3'd0, d); chk("R2 enable only", d, 32'h1);
    bus_write(3'd0, 32'hFFFF_FFF7); rd(3'd0, d); chk("R1 upper bits zero", d, 32'h3);

    // flush walks
    bus_write(3'd1, 32'h0); chk("R3 zero write no walk", 32'(tag_clr_o), 32'd0);
    bus_write(3'd1, 32'h1); check_walk("R3 walk");
    bus_write(3'd1, 32'h1);
    repeat (5) @(posedge clk); #1;
    chk("R7 mid walk idx", 32'(tag_idx_o), 32'd5);
    bus_write(3'd1, 32'h1); check_walk("R7 restart");

    // unmapped address
    rd(3'd0, ctrl_before);
    bus_read(3'd5, d, w, e); chk("R11 err read", 32'(e), 32'd1);
    bus_write(3'd6, 32'h0); rd(3'd0, d); chk("R11 write ignored", d, ctrl_before);
    bus_read(3'd4, d, w, e); chk("R11 no err mapped", 32'(e), 32'd0);

    // counters: random strobes against a saturating model
    bus_write(3'd3, 32'h5A); bus_write(3'd4, 32'hFFFF);
    rd(3'd3, d); chk("R9 hit cleared", d, 32'd0);
    rd(3'd4, d); chk("R9 acc cleared", d, 32'd0);
    for (int round = 0; round < 4; round++) begin
      hc = 0; ac = 0;
      bus_write(3'd3, 32'h0); bus_write(3'd4, 32'h0);
      for (int i = 0; i < 30 + round * 15; i++) begin
        @(negedge clk);
        acc_stb = ($urandom % 4) != 0;
        hit_stb = acc_stb && ($urandom % 2);
        hc += int'(hit_stb); ac += int'(acc_stb);
      end
      @(negedge clk); hit_stb = 0; acc_stb = 0;
      rd(3'd3, d); chk("R10 hit count", d, 32'(sat(hc)));
      rd(3'd4, d); chk("R10 acc count", d, 32'(sat(ac)));
    end

    // saturation
    bus_write(3'd4, 32'h0);
    @(negedge clk); acc_stb = 1;
    repeat (CMAX + 10) @(negedge clk);
    acc_stb = 0;
    rd(3'd4, d); chk("R8 acc saturates", d, 32'(CMAX));

    // clear and increment in the same cycle
    bus_write(3'd3, 32'h0);
    @(negedge clk); hit_stb = 1;
    @(negedge clk); req = 1; we = 1; addr = 3'd3; wdata = 32'h1;
    @(posedge clk); #1; req = 0; we = 0; hit_stb = 0;
    rd(3'd3, d); chk("R9 clear wins", d, 32'd0);
    rd(3'd4, d); chk("R8 acc held at max", d, 32'(CMAX));

    finish_up();
  end
endmodule